// File: doc/BRIEF.md
# Shared group status bus port

This block is one port's share of a status bus that several ports use together. Up to eight independent ports are wired onto one 8-bit read data bus. Each port is given its own bit lane. When the host reads one of four group information addresses, every port answers at once on its own lane, so a single read collects one status bit from each port in the group. The first information address returns each port's interrupt flag. The second returns each port's receive loss-of-sync flag. The third and fourth each return an alarm that software picks per port from an 8-entry alarm vector.

Software sets the port up through two byte-wide configuration registers on the same host bus. The first holds the reporting enable and the 3-bit lane number. The second holds the two 3-bit alarm selectors. The output is an 8-bit data vector with a drive enable for each bit. A lane whose enable is low carries 0, so the group bus can be formed as the OR of every port's data.

Top module: `grp_stat_port`

## Requirements
- R1: After reset both configuration registers read back as 0x00, and a read of any information address drives no lane.
- R2: A write to address 0x0 loads configuration register 1: bit 0 is the reporting enable (1 = on), bits 3:1 are the lane number, and bits 7:4 always read 0. A host read of address 0x0 drives all eight lanes (enable 0xFF) with the register value.
- R3: A write to address 0x1 loads configuration register 2: bits 2:0 are selector A, bits 6:4 are selector B, and bits 3 and 7 always read 0. A host read of address 0x1 drives all eight lanes with the register value.
- R4: With reporting on, a read of address 0x8 drives only the configured lane, and that lane carries int_i.
- R5: With reporting on, a read of address 0x9 drives only the configured lane, and that lane carries los_i.
- R6: With reporting on, a read of address 0xA drives alarm_i[selector A] on the configured lane, and a read of 0xB drives alarm_i[selector B]. Any selector value from 0 to 7 is accepted.
- R7: With reporting off, a read of 0x8 to 0xB drives no lane. A read of any address other than 0x0, 0x1 or 0x8 to 0xB drives no lane, whether reporting is on or off.
- R8: While rd_i is low, bus_oe_o and bus_o are both 0.
- R9: Every bit of bus_o whose drive enable is low is 0.
- R10: A write to an address other than 0x0 or 0x1 leaves both configuration registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Host register address |
| wdata_i | input | 8 | Host write data |
| we_i | input | 1 | Host write strobe, sampled on the clock edge |
| rd_i | input | 1 | Read strobe, acts combinationally |
| int_i | input | 1 | Port interrupt flag |
| los_i | input | 1 | Port receive loss-of-sync flag |
| alarm_i | input | 8 | Alarm vector indexed by the selectors |
| bus_o | output | 8 | Read data for this port |
| bus_oe_o | output | 8 | Per-bit drive enable |

## Verification
The hardest case to reach is a selector index that actually changes the result. The alarm selectors, the lane number and the alarm vector all have to line up so that a wrong index would give a different bit on the lane being checked. A fixed set of patterns rarely does this. The stimulus therefore rewrites both configuration registers at random between reads and randomizes the alarm vector on every read. It also sweeps every lane with both selectors set to each of the eight values, using walking-one alarm patterns, so a crossed index or a wrong lane shows up as a wrong bit.

// File: rtl/gsp_pkg.sv
package gsp_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned LANE_W = $clog2(DATA_W);
  localparam int unsigned ADDR_W = 4;

  typedef enum logic [1:0] {
    INFO_INT = 2'd0,
    INFO_LOS = 2'd1,
    INFO_SLA = 2'd2,
    INFO_SLB = 2'd3
  } info_e;

  typedef struct packed {
    logic              en;
    logic [LANE_W-1:0] lane;
    logic [LANE_W-1:0] sel_a;
    logic [LANE_W-1:0] sel_b;
  } cfg_t;
endpackage

// File: rtl/gsp_addr_dec.sv
module gsp_addr_dec
  import gsp_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CFG1_ADDR = 4'h0,
  parameter logic [ADDR_W-1:0] CFG2_ADDR = 4'h1,
  parameter logic [ADDR_W-1:0] INFO_BASE = 4'h8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_cfg1_o,
  output logic              hit_cfg2_o,
  output logic              hit_info_o,
  output info_e             info_o
);
  assign hit_cfg1_o = (addr_i == CFG1_ADDR);
  assign hit_cfg2_o = (addr_i == CFG2_ADDR);
  // info block is four aligned addresses
  assign hit_info_o = (addr_i[ADDR_W-1:2] == INFO_BASE[ADDR_W-1:2]);
  assign info_o     = info_e'(addr_i[1:0]);
endmodule

// File: rtl/gsp_cfg_regs.sv
module gsp_cfg_regs
  import gsp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              hit_cfg1_i,
  input  logic              hit_cfg2_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] img1_o,
  output logic [DATA_W-1:0] img2_o,
  output cfg_t              cfg_o
);
  localparam logic [DATA_W-1:0] MASK1 = DATA_W'((1 << (LANE_W + 1)) - 1);
  localparam logic [DATA_W-1:0] MASK2 = 8'h77;

  logic [DATA_W-1:0] img1_q, img2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      img1_q <= '0;
      img2_q <= '0;
    end else if (we_i) begin
      if (hit_cfg1_i) img1_q <= wdata_i & MASK1;
      if (hit_cfg2_i) img2_q <= wdata_i & MASK2;
    end
  end

  assign img1_o      = img1_q;
  assign img2_o      = img2_q;
  assign cfg_o.en    = img1_q[0];
  assign cfg_o.lane  = img1_q[LANE_W:1];
  assign cfg_o.sel_a = img2_q[LANE_W-1:0];
  assign cfg_o.sel_b = img2_q[LANE_W+3:4];

  AST_LANE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && hit_cfg1_i) |=> (cfg_o.lane == $past(wdata_i[LANE_W:1])))
    else $error("lane load"); // R2
  AST_SEL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && hit_cfg2_i) |=> (cfg_o.sel_b == $past(wdata_i[LANE_W+3:4])))
    else $error("selector load"); // R3
  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(we_i && (hit_cfg1_i || hit_cfg2_i))) |=> ($stable(img1_q) && $stable(img2_q)))
    else $error("config changed"); // R10
endmodule

// File: rtl/gsp_stat_mux.sv
module gsp_stat_mux
  import gsp_pkg::*;
(
  input  info_e             info_i,
  input  cfg_t              cfg_i,
  input  logic              int_i,
  input  logic              los_i,
  input  logic [DATA_W-1:0] alarm_i,
  output logic              stat_o
);
  always_comb begin
    unique case (info_i)
      INFO_INT: stat_o = int_i;
      INFO_LOS: stat_o = los_i;
      INFO_SLA: stat_o = alarm_i[cfg_i.sel_a];
      default:  stat_o = alarm_i[cfg_i.sel_b];
    endcase
  end
endmodule

// File: rtl/grp_stat_port.sv
module grp_stat_port
  import gsp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              rd_i,
  input  logic              int_i,
  input  logic              los_i,
  input  logic [DATA_W-1:0] alarm_i,
  output logic [DATA_W-1:0] bus_o,
  output logic [DATA_W-1:0] bus_oe_o
);
  logic              hit_cfg1, hit_cfg2, hit_info;
  info_e             info;
  logic [DATA_W-1:0] img1, img2;
  cfg_t              cfg;
  logic              stat;
  logic              grp_drv;
  logic [DATA_W-1:0] grp_oe, grp_dat;

  gsp_addr_dec i_dec (
    .addr_i     (addr_i),
    .hit_cfg1_o (hit_cfg1),
    .hit_cfg2_o (hit_cfg2),
    .hit_info_o (hit_info),
    .info_o     (info)
  );

  gsp_cfg_regs i_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (we_i),
    .hit_cfg1_i (hit_cfg1),
    .hit_cfg2_i (hit_cfg2),
    .wdata_i    (wdata_i),
    .img1_o     (img1),
    .img2_o     (img2),
    .cfg_o      (cfg)
  );

  gsp_stat_mux i_mux (
    .info_i  (info),
    .cfg_i   (cfg),
    .int_i   (int_i),
    .los_i   (los_i),
    .alarm_i (alarm_i),
    .stat_o  (stat)
  );

  assign grp_drv = rd_i && hit_info && cfg.en;

  for (genvar l = 0; l < DATA_W; l++) begin : g_lane
    assign grp_oe[l]  = grp_drv && (cfg.lane == LANE_W'(l));
    assign grp_dat[l] = grp_oe[l] && stat;
  end

  always_comb begin
    bus_o    = '0;
    bus_oe_o = '0;
    if (rd_i && hit_cfg1) begin
      bus_o    = img1;
      bus_oe_o = '1;
    end else if (rd_i && hit_cfg2) begin
      bus_o    = img2;
      bus_oe_o = '1;
    end else begin
      bus_o    = grp_dat;
      bus_oe_o = grp_oe;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> (bus_oe_o == '0 && bus_o == '0)) else $error("idle drive"); // R8
  AST_UNDRIVEN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |-> ((bus_o & ~bus_oe_o) == '0)) else $error("undriven bit set"); // R9
  AST_LANE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && hit_info && cfg.en) |-> ($onehot(bus_oe_o) && bus_oe_o[cfg.lane]))
    else $error("lane select"); // R4
  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && hit_info && !cfg.en) |-> (bus_oe_o == '0)) else $error("drive while off"); // R7
endmodule

// File: tb/test_grp_stat_port.sv
`timescale 1ns/1ps
module test_grp_stat_port;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic       we_i = 1'b0;
  logic       rd_i = 1'b0;
  logic       int_i = 1'b0;
  logic       los_i = 1'b0;
  logic [7:0] alarm_i = '0;
  logic [7:0] bus_o, bus_oe_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // model of configuration
  logic       m_en;
  logic [2:0] m_lane, m_sa, m_sb;

  always #5 clk_i = ~clk_i;

  grp_stat_port i_grp_stat_port (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .we_i, .rd_i,
    .int_i, .los_i, .alarm_i, .bus_o, .bus_oe_o
  );

  function automatic logic [15:0] expect_bus(input logic [3:0] a, input logic rd);
    logic bitv;
    if (!rd) return 16'h0;
    if (a == 4'h0) return {8'hFF, 4'b0, m_lane, m_en};
    if (a == 4'h1) return {8'hFF, 1'b0, m_sb, 1'b0, m_sa};
    if (a[3:2] == 2'b10 && m_en) begin
      case (a[1:0])
        2'd0: bitv = int_i;
        2'd1: bitv = los_i;
        2'd2: bitv = alarm_i[m_sa];
        default: bitv = alarm_i[m_sb];
      endcase
      return {8'(1 << m_lane), 8'(bitv) << m_lane};
    end
    return 16'h0;
  endfunction

  task automatic check(input string req, input logic [15:0] exp);
    n_chk++;
    if ({bus_oe_o, bus_o} !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h oe/data act=%h/%h exp=%h/%h", req, addr_i,
               bus_oe_o, bus_o, exp[15:8], exp[7:0]);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
    if (a == 4'h0) begin m_en = d[0]; m_lane = d[3:1]; end
    if (a == 4'h1) begin m_sa = d[2:0]; m_sb = d[6:4]; end
  endtask

  task automatic rd(input string req, input logic [3:0] a);
    @(negedge clk_i);
    addr_i = a; rd_i = 1'b1;
    #1 check(req, expect_bus(a, 1'b1));
    @(negedge clk_i);
    rd_i = 1'b0;
    #1 check("R8", 16'h0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_en = 0; m_lane = 0; m_sa = 0; m_sb = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    rd("R1", 4'h0);
    rd("R1", 4'h1);
    int_i = 1'b1;
    rd("R1", 4'h8);
    // R2 / R3 reserved bits masked
    wr(4'h0, 8'hFF); rd("R2", 4'h0);
    wr(4'h1, 8'hFF); rd("R3", 4'h1);
    // R10 writes elsewhere ignored
    wr(4'h8, 8'h00); wr(4'h5, 8'h00); wr(4'hF, 8'h00);
    rd("R10", 4'h0); rd("R10", 4'h1);
    // R4 / R5
    int_i = 1'b1; los_i = 1'b0; rd("R4", 4'h8); rd("R5", 4'h9);
    int_i = 1'b0; los_i = 1'b1; rd("R4", 4'h8); rd("R5", 4'h9);
    // R7 unmapped addresses while on
    for (int a = 2; a < 8; a++) rd("R7", 4'(a));
    for (int a = 12; a < 16; a++) rd("R7", 4'(a));
    // R6 sweep lanes and selectors with walking-one alarms
    for (int l = 0; l < 8; l++) begin
      wr(4'h0, 8'({l[2:0], 1'b1}));
      for (int s = 0; s < 8; s++) begin
        wr(4'h1, 8'({1'b0, 3'(7 - s), 1'b0, 3'(s)}));
        alarm_i = 8'(1 << s); rd("R6", 4'hA); rd("R6", 4'hB);
        alarm_i = 8'(1 << (7 - s)); rd("R6", 4'hA); rd("R6", 4'hB);
      end
    end
    // R7 disabled
    wr(4'h0, 8'h0A); int_i = 1'b1; los_i = 1'b1; alarm_i = 8'hFF;
    for (int a = 8; a < 12; a++) rd("R7", 4'(a));
    // random mix
    for (int i = 0; i < 600; i++) begin
      int k = $urandom_range(0, 9);
      if (k == 0) wr(4'h0, 8'($urandom));
      else if (k == 1) wr(4'h1, 8'($urandom));
      else if (k == 2) wr(4'($urandom), 8'($urandom));
      else begin
        int_i = 1'($urandom); los_i = 1'($urandom); alarm_i = 8'($urandom);
        rd("R9", ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'(8 + $urandom_range(0, 3)));
      end
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule